// File: doc/BRIEF.md
# Host Port Slave Controller

This block is the slave side of an asynchronous 16-bit host port. The host reaches 32-bit internal registers and memory words as two half-word transfers. A host cycle is framed by an internal active-low strobe built from a chip select and two data strobes. The block decodes each cycle to one of three registers: a 16-bit control register, a 32-bit address register, or a 32-bit data register. Data register accesses reach internal memory through a simple request/acknowledge port.

Every host input is first brought into the core clock domain through a two-flop synchroniser. The select lines, read/write line and half-word flag are captured in one of two places. If the address strobe is in use, they are captured at its falling edge. Otherwise they are captured when the internal strobe falls.

While a data access waits on memory, the block drives a busy line. That line only shows busy while chip select is active. Memory-side work is needed in three cases: a first-half data read fetches the word, a second-half data write stores the assembled word, and a second-half auto-increment read prefetches the next word. An auto-increment access steps the address register by one word.

Top module: `host_port_ctrl`

## Requirements
- R1: The internal strobe is low exactly when chip select is low and exactly one of the two data strobes is low. With both data strobes low, both high, or chip select high, no access takes place.
- R2: When the address strobe is low at the start of a cycle, the cycle uses the select, read/write and half values captured at the falling edge of the address strobe, and ignores their later values.
- R3: The busy output is low whenever chip select is high, even while a memory operation is in flight. When chip select falls during such an operation, busy goes high.
- R4: The select encoding is 00 = control, 01 = data with auto-increment, 10 = address, 11 = data without increment. Accesses to the control or address register never issue a memory request and never raise busy.
- R5: On a first-half (half=0) read of the data register, a memory read of the word at the address register is issued. Busy stays high until that word is loaded. Half 0 returns bits 31:16 of the word and half 1 returns bits 15:0.
- R6: A memory request, together with its address, write flag and write data, is held stable until it is acknowledged.
- R7: On a data write, the rising strobe of half 0 captures the upper 16 bits. The rising strobe of half 1 captures the lower 16 bits and issues a 32-bit memory write of {upper, lower} at the address register, with busy high until it is acknowledged.
- R8: After the second half of a word access with select 01, the address register increases by 4. A word access with select 11 leaves the address register unchanged.
- R9: After the second half of an auto-increment read, the block prefetches the word at the incremented address, with busy high until it arrives. The next first-half auto-increment read then returns that word without a new memory request.
- R10: The data output enable is high only while the strobe is low during a read cycle.
- R11: Address register writes with half 0 set bits 31:16 and writes with half 1 set bits 15:0, and both halves read back. The control register is 16 bits wide: a write of either half sets it, and a read of either half returns it. Both registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_ds1_n | input | 1 | Host data strobe one, active low |
| hp_ds2_n | input | 1 | Host data strobe two, active low |
| hp_as_n | input | 1 | Host address strobe, active low; captures the selects on its fall |
| hp_sel | input | 2 | Register select (00 control, 01 data inc, 10 address, 11 data) |
| hp_rnw | input | 1 | 1 = read, 0 = write |
| hp_half | input | 1 | 0 = upper half-word, 1 = lower half-word |
| hp_din | input | 16 | Host write data |
| hp_dout | output | 16 | Host read data |
| hp_dout_en | output | 1 | Output enable for the host data bus |
| hp_busy | output | 1 | High while the port is busy, gated by chip select |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |

## Verification
The bench targets the strobe combinations that must not start a cycle: both data strobes low, and a data strobe low while chip select is high. A wrong strobe decode would corrupt the control register in these cases. It also changes the selects after the address strobe has fallen; a design that failed to hold the latched values would turn an address write into a data read and issue a stray memory request. Chip select is raised and lowered while a write is still in flight. A busy line that is not gated, or that is latched, would show there. Auto-increment is tracked by counting requests and reading the address back. A design that skipped the prefetch, fetched twice, or stepped the address on a non-incrementing access returns the wrong word or the wrong address.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

    typedef enum logic [1:0] {
        REG_CTRL     = 2'b00,
        REG_DATA_INC = 2'b01,
        REG_ADDR     = 2'b10,
        REG_DATA     = 2'b11
    } reg_sel_e;

    localparam int HOST_W_DEF   = 16;
    localparam int SYNC_DEPTH   = 2;
    localparam int WORD_STEP    = 4;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/hp_strobe.sv
module hp_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic ds1_n_s,
    input  logic ds2_n_s,
    input  logic as_n_s,
    output logic stb_n,
    output logic as_fall
);
    logic as_prev_d, as_prev_q;

    always_comb begin
        as_prev_d = as_n_s;
        stb_n     = ~(ds1_n_s ^ ds2_n_s) | cs_n_s;
        as_fall   = as_prev_q & ~as_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) as_prev_q <= 1'b1;
        else        as_prev_q <= as_prev_d;
    end
endmodule

// File: rtl/hp_core.sv
module hp_core
    import host_port_pkg::*;
#(
    parameter int HOST_W    = HOST_W_DEF,
    parameter int ADDR_STEP = WORD_STEP
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stb_n,
    input  logic                  cs_n,
    input  logic                  as_n,
    input  logic                  as_fall,
    input  logic [1:0]            sel_in,
    input  logic                  rnw_in,
    input  logic                  half_in,
    input  logic [HOST_W-1:0]     din,
    output logic [HOST_W-1:0]     dout,
    output logic                  dout_en,
    output logic                  busy,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [2*HOST_W-1:0]   mem_addr,
    output logic [2*HOST_W-1:0]   mem_wdata,
    input  logic                  mem_ack,
    input  logic [2*HOST_W-1:0]   mem_rdata
);
    localparam int              WW     = 2 * HOST_W;
    localparam logic [WW-1:0]   STEP_V = WW'(ADDR_STEP);

    typedef struct packed {
        logic              in_cyc;
        reg_sel_e          cyc_sel;
        logic              cyc_rnw;
        logic              cyc_half;
        reg_sel_e          as_sel;
        logic              as_rnw;
        logic              as_half;
        logic [HOST_W-1:0] ctrl;
        logic [WW-1:0]     addr;
        logic [WW-1:0]     data;
        logic              pf_valid;
        logic              req;
        logic              we;
        logic              pf;
        logic [WW-1:0]     maddr;
        logic [WW-1:0]     wdata;
    } st_t;

    st_t      st_d, st_q;
    logic     start, finish;
    reg_sel_e s_sel;
    logic     s_rnw, s_half;

    always_comb begin
        st_d   = st_q;
        start  = !stb_n && !st_q.in_cyc && !st_q.req;
        finish = stb_n && st_q.in_cyc;
        s_sel  = as_n ? reg_sel_e'(sel_in) : st_q.as_sel;
        s_rnw  = as_n ? rnw_in  : st_q.as_rnw;
        s_half = as_n ? half_in : st_q.as_half;

        if (as_fall) begin
            st_d.as_sel  = reg_sel_e'(sel_in);
            st_d.as_rnw  = rnw_in;
            st_d.as_half = half_in;
        end

        // memory completion
        if (st_q.req && mem_ack) begin
            st_d.req = 1'b0;
            if (!st_q.we) begin
                st_d.data = mem_rdata;
                if (st_q.pf) st_d.pf_valid = 1'b1;
            end
        end

        // cycle start on strobe low
        if (start) begin
            st_d.in_cyc   = 1'b1;
            st_d.cyc_sel  = s_sel;
            st_d.cyc_rnw  = s_rnw;
            st_d.cyc_half = s_half;
            if (s_rnw && s_sel[0] && !s_half &&
                !(s_sel == REG_DATA_INC && st_q.pf_valid)) begin
                st_d.req   = 1'b1;
                st_d.we    = 1'b0;
                st_d.pf    = 1'b0;
                st_d.maddr = st_q.addr;
            end
        end

        // cycle end on strobe high
        if (finish) begin
            st_d.in_cyc = 1'b0;
            if (!st_q.cyc_rnw) begin
                case (st_q.cyc_sel)
                    REG_CTRL: st_d.ctrl = din;
                    REG_ADDR: begin
                        if (st_q.cyc_half) st_d.addr[HOST_W-1:0]  = din;
                        else               st_d.addr[WW-1:HOST_W] = din;
                        st_d.pf_valid = 1'b0;
                    end
                    default: begin
                        if (!st_q.cyc_half) begin
                            st_d.data[WW-1:HOST_W] = din;
                        end else begin
                            st_d.data[HOST_W-1:0] = din;
                            st_d.req      = 1'b1;
                            st_d.we       = 1'b1;
                            st_d.pf       = 1'b0;
                            st_d.maddr    = st_q.addr;
                            st_d.wdata    = {st_q.data[WW-1:HOST_W], din};
                            st_d.pf_valid = 1'b0;
                            if (st_q.cyc_sel == REG_DATA_INC)
                                st_d.addr = st_q.addr + STEP_V;
                        end
                    end
                endcase
            end else if (st_q.cyc_sel == REG_DATA_INC && st_q.cyc_half) begin
                st_d.addr     = st_q.addr + STEP_V;
                st_d.req      = 1'b1;
                st_d.we       = 1'b0;
                st_d.pf       = 1'b1;
                st_d.maddr    = st_q.addr + STEP_V;
                st_d.pf_valid = 1'b0;
            end
        end

        case (st_q.cyc_sel)
            REG_CTRL: dout = st_q.ctrl;
            REG_ADDR: dout = st_q.cyc_half ? st_q.addr[HOST_W-1:0] : st_q.addr[WW-1:HOST_W];
            default:  dout = st_q.cyc_half ? st_q.data[HOST_W-1:0] : st_q.data[WW-1:HOST_W];
        endcase
        dout_en   = st_q.in_cyc && st_q.cyc_rnw && !stb_n;
        busy      = st_q.req && !cs_n;
        mem_req   = st_q.req;
        mem_we    = st_q.we;
        mem_addr  = st_q.maddr;
        mem_wdata = st_q.wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{in_cyc: 1'b0, cyc_sel: REG_CTRL, cyc_rnw: 1'b0, cyc_half: 1'b0,
                      as_sel: REG_CTRL, as_rnw: 1'b0, as_half: 1'b0,
                      ctrl: '0, addr: '0, data: '0, pf_valid: 1'b0,
                      req: 1'b0, we: 1'b0, pf: 1'b0, maddr: '0, wdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R4: register-only cycles never raise a memory request
    a_r4_regs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_cyc && !st_q.cyc_sel[0] && !st_q.req) |=> !st_q.req);

    // R5: first-half plain data read fetches the current address
    a_r5_read_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && s_rnw && s_sel == REG_DATA && !s_half)
        |=> (st_q.req && !st_q.we && st_q.maddr == $past(st_q.addr)));

    // R6: request fields held until acknowledge
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !mem_ack)
        |=> (st_q.req && $stable(st_q.maddr) && $stable(st_q.wdata) && $stable(st_q.we)));

    // R7: second-half data write issues a memory write
    a_r7_write_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !st_q.cyc_rnw && st_q.cyc_sel[0] && st_q.cyc_half)
        |=> (st_q.req && st_q.we));

    // R8: auto-increment write steps the address by one word
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !st_q.cyc_rnw && st_q.cyc_sel == REG_DATA_INC && st_q.cyc_half)
        |=> (st_q.addr == $past(st_q.addr) + STEP_V));

    // R10: output enable never on while strobe is high
    a_r10_oe_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        stb_n |-> !dout_en);
endmodule

// File: rtl/host_port_ctrl.sv
module host_port_ctrl
    import host_port_pkg::*;
#(
    parameter int HOST_W    = HOST_W_DEF,
    parameter int SYNC_N    = SYNC_DEPTH,
    parameter int ADDR_STEP = WORD_STEP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hp_cs_n,
    input  logic                hp_ds1_n,
    input  logic                hp_ds2_n,
    input  logic                hp_as_n,
    input  logic [1:0]          hp_sel,
    input  logic                hp_rnw,
    input  logic                hp_half,
    input  logic [HOST_W-1:0]   hp_din,
    output logic [HOST_W-1:0]   hp_dout,
    output logic                hp_dout_en,
    output logic                hp_busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [2*HOST_W-1:0] mem_addr,
    output logic [2*HOST_W-1:0] mem_wdata,
    input  logic                mem_ack,
    input  logic [2*HOST_W-1:0] mem_rdata
);
    localparam int CTL_W = 8;

    logic [CTL_W-1:0]  ctl_s;
    logic [HOST_W-1:0] din_s;
    logic              stb_n, as_fall;

    hp_sync #(.WIDTH(CTL_W), .STAGES(SYNC_N), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({hp_cs_n, hp_ds1_n, hp_ds2_n, hp_as_n, hp_sel, hp_rnw, hp_half}),
        .d_out (ctl_s)
    );

    hp_sync #(.WIDTH(HOST_W), .STAGES(SYNC_N), .RST_VAL('0)) u_sync_din (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (hp_din),
        .d_out (din_s)
    );

    hp_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (ctl_s[7]),
        .ds1_n_s (ctl_s[6]),
        .ds2_n_s (ctl_s[5]),
        .as_n_s  (ctl_s[4]),
        .stb_n   (stb_n),
        .as_fall (as_fall)
    );

    hp_core #(.HOST_W(HOST_W), .ADDR_STEP(ADDR_STEP)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_n     (stb_n),
        .cs_n      (ctl_s[7]),
        .as_n      (ctl_s[4]),
        .as_fall   (as_fall),
        .sel_in    (ctl_s[3:2]),
        .rnw_in    (ctl_s[1]),
        .half_in   (ctl_s[0]),
        .din       (din_s),
        .dout      (hp_dout),
        .dout_en   (hp_dout_en),
        .busy      (hp_busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );
endmodule

// File: tb/tb_host_port_ctrl.sv
module tb_host_port_ctrl;
    localparam int LAT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_cs_n = 1'b1, hp_ds1_n = 1'b1, hp_ds2_n = 1'b1, hp_as_n = 1'b1;
    logic [1:0]  hp_sel = 2'b00;
    logic        hp_rnw = 1'b1, hp_half = 1'b0;
    logic [15:0] hp_din = '0;
    logic [15:0] hp_dout;
    logic        hp_dout_en, hp_busy;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int failures = 0;
    int req_cnt = 0;
    logic req_prev = 1'b0;
    int cnt = 0;
    logic [31:0] mem [16];
    logic [31:0] exp_mem [16];

    always #2 clk = ~clk;

    host_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hp_cs_n(hp_cs_n), .hp_ds1_n(hp_ds1_n),
        .hp_ds2_n(hp_ds2_n), .hp_as_n(hp_as_n), .hp_sel(hp_sel), .hp_rnw(hp_rnw),
        .hp_half(hp_half), .hp_din(hp_din), .hp_dout(hp_dout), .hp_dout_en(hp_dout_en),
        .hp_busy(hp_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0103_0507;
    endfunction

    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        req_prev <= mem_req;
        if (mem_req && !req_prev) req_cnt <= req_cnt + 1;
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            if (cnt == LAT) begin
                mem_ack <= 1'b1;
                cnt <= 0;
                if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[5:2]];
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // mode: 0 = ds1 low, 1 = ds2 low, 2 = both low, 3 = ds1 low with chip select high
    task automatic xfer(input logic [1:0] s, input logic r, input logic h, input logic [15:0] wd,
                        input int mode, input bit use_as, output logic [15:0] rd, output logic oe);
        int g;
        while (mem_req) @(negedge clk);
        repeat (3) @(negedge clk);
        hp_cs_n = (mode == 3);
        hp_sel = s; hp_rnw = r; hp_half = h; hp_din = wd;
        if (use_as) begin
            @(negedge clk);
            hp_as_n = 1'b0;
            repeat (4) @(negedge clk);
            hp_sel = ~s; hp_rnw = ~r; hp_half = ~h;
        end
        @(negedge clk);
        case (mode)
            1: hp_ds2_n = 1'b0;
            2: begin hp_ds1_n = 1'b0; hp_ds2_n = 1'b0; end
            default: hp_ds1_n = 1'b0;
        endcase
        repeat (5) @(negedge clk);
        g = 0;
        while (hp_busy && g < 5000) begin @(negedge clk); g++; end
        repeat (2) @(negedge clk);
        rd = hp_dout;
        oe = hp_dout_en;
        hp_ds1_n = 1'b1; hp_ds2_n = 1'b1;
        repeat (5) @(negedge clk);
        hp_as_n = 1'b1;
        hp_cs_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] s, input logic h, input logic [15:0] wd);
        logic [15:0] rd; logic oe;
        xfer(s, 1'b0, h, wd, 0, 1'b0, rd, oe);
        chk("R10 write oe", {31'b0, oe}, 32'd0);
    endtask

    task automatic rd16(input logic [1:0] s, input logic h, input int mode, output logic [15:0] v);
        logic oe;
        xfer(s, 1'b1, h, 16'h0, mode, 1'b0, v, oe);
        chk("R10 read oe", {31'b0, oe}, 32'd1);
    endtask

    task automatic set_addr(input logic [31:0] a);
        wr(2'b10, 1'b0, a[31:16]);
        wr(2'b10, 1'b1, a[15:0]);
    endtask

    task automatic get_addr(output logic [31:0] a);
        logic [15:0] hi, lo;
        rd16(2'b10, 1'b0, 0, hi);
        rd16(2'b10, 1'b1, 0, lo);
        a = {hi, lo};
    endtask

    initial begin
        logic [15:0] v, v2;
        logic [31:0] a;
        logic oe;
        int rc;
        for (int i = 0; i < 16; i++) begin
            mem[i] = init_word(i);
            exp_mem[i] = init_word(i);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state (R3, R10, R11)
        chk("R3 reset busy", {31'b0, hp_busy}, 32'd0);
        chk("R10 reset oe", {31'b0, hp_dout_en}, 32'd0);
        chk("R6 reset req", {31'b0, mem_req}, 32'd0);
        get_addr(a);
        chk("R11 reset addr", a, 32'd0);
        rd16(2'b00, 1'b0, 0, v);
        chk("R11 reset ctrl", {16'b0, v}, 32'd0);

        // control register and strobe decode (R1, R11, R4)
        rc = req_cnt;
        wr(2'b00, 1'b0, 16'hBEEF);
        rd16(2'b00, 1'b1, 0, v);
        chk("R11 ctrl either half", {16'b0, v}, 32'h0000BEEF);
        xfer(2'b00, 1'b0, 1'b0, 16'h1234, 2, 1'b0, v, oe);
        rd16(2'b00, 1'b0, 0, v);
        chk("R1 both strobes low ignored", {16'b0, v}, 32'h0000BEEF);
        xfer(2'b00, 1'b0, 1'b0, 16'h4321, 3, 1'b0, v, oe);
        rd16(2'b00, 1'b0, 0, v);
        chk("R1 chip select high ignored", {16'b0, v}, 32'h0000BEEF);
        xfer(2'b00, 1'b0, 1'b1, 16'h5A5A, 1, 1'b0, v, oe);
        rd16(2'b00, 1'b0, 1, v);
        chk("R1 second strobe alone", {16'b0, v}, 32'h00005A5A);

        // address capture on address strobe (R2)
        xfer(2'b10, 1'b0, 1'b0, 16'hA1B2, 0, 1'b1, v, oe);
        xfer(2'b10, 1'b0, 1'b1, 16'h0C3C, 0, 1'b1, v, oe);
        get_addr(a);
        chk("R2 latched selects", a, 32'hA1B20C3C);
        chk("R4 no request from register traffic", 32'(req_cnt - rc), 32'd0);

        // sweep plain data reads over all words (R5, R8)
        for (int i = 0; i < 16; i++) begin
            set_addr(32'(i * 4));
            rc = req_cnt;
            rd16(2'b11, 1'b0, i % 2, v);
            rd16(2'b11, 1'b1, (i + 1) % 2, v2);
            chk("R5 read word", {v, v2}, exp_mem[i]);
            chk("R5 one request", 32'(req_cnt - rc), 32'd1);
            get_addr(a);
            chk("R8 no step on select 11", a, 32'(i * 4));
        end

        // data write and chip-select gating of busy (R7, R3)
        set_addr(32'h0000_000C);
        wr(2'b11, 1'b0, 16'hCAFE);
        wr(2'b11, 1'b1, 16'hF00D);
        exp_mem[3] = 32'hCAFEF00D;
        repeat (3) @(negedge clk);
        chk("R3 request in flight", {31'b0, mem_req}, 32'd1);
        chk("R3 busy low with chip select high", {31'b0, hp_busy}, 32'd0);
        hp_cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 busy on chip select fall", {31'b0, hp_busy}, 32'd1);
        while (mem_req) @(negedge clk);
        @(negedge clk);
        chk("R3 busy clears", {31'b0, hp_busy}, 32'd0);
        hp_cs_n = 1'b1;
        rd16(2'b11, 1'b0, 0, v);
        rd16(2'b11, 1'b1, 0, v2);
        chk("R7 written word", {v, v2}, exp_mem[3]);

        // auto-increment read with prefetch (R9, R8)
        set_addr(32'h0000_0010);
        rc = req_cnt;
        rd16(2'b01, 1'b0, 0, v);
        rd16(2'b01, 1'b1, 0, v2);
        chk("R9 first word", {v, v2}, exp_mem[4]);
        while (mem_req) @(negedge clk);
        chk("R9 prefetch issued", 32'(req_cnt - rc), 32'd2);
        get_addr(a);
        chk("R8 step on select 01 read", a, 32'h14);
        rc = req_cnt;
        rd16(2'b01, 1'b0, 0, v);
        chk("R9 no request on prefetched half", 32'(req_cnt - rc), 32'd0);
        rd16(2'b01, 1'b1, 0, v2);
        chk("R9 prefetched word", {v, v2}, exp_mem[5]);

        // auto-increment write (R8, R7)
        set_addr(32'h0000_0020);
        wr(2'b01, 1'b0, 16'h1357);
        wr(2'b01, 1'b1, 16'h9BDF);
        exp_mem[8] = 32'h13579BDF;
        get_addr(a);
        chk("R8 step on select 01 write", a, 32'h24);
        set_addr(32'h0000_0020);
        rd16(2'b11, 1'b0, 0, v);
        rd16(2'b11, 1'b1, 0, v2);
        chk("R7 incrementing write data", {v, v2}, exp_mem[8]);
        repeat (4) @(negedge clk);
        chk("R10 idle oe", {31'b0, hp_dout_en}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule